// File: doc/BRIEF.md
# Limit-Match System Counter-Timer

This block is one memory-mapped counter-timer channel with 32-bit word registers. An up-counter advances once per tick-enable pulse, one pulse every 500 ns. Its value is kept in bits 30..9 of the count word, so each tick adds 0x200 to the word. When the count reaches a nonzero programmed limit, the block sets a sticky reached flag in bit 31 and raises a level interrupt. On the following tick the count restarts from zero. A limit of zero turns the channel into a free-running counter that never matches.

Software programs the channel through a small word-addressed window. One limit address restarts the count and another leaves the running count alone. A read of the limit acknowledges the interrupt. The window also holds a per-processor mode register, with one bit per CPU. This block only stores those bits and drives them out to the processor-side logic that decodes them. Read data comes back one clock after the request, qualified by a valid strobe.

Top module: `tmr_top`

## Requirements
- R1: After reset the limit, count, reached flag, interrupt and mode register are all zero, and the counter is running.
- R2: The count occupies bits 30..9 of a count read (word offset 1) and bits 8..0 read zero. Each tick-enable pulse adds one at bit 9. Without a pulse the count holds.
- R3: With a nonzero limit, the tick that brings the count equal to the limit sets the reached flag (bit 31 of a count read) and the interrupt. The next tick reloads the count to zero.
- R4: The interrupt is a level that stays high across further ticks and count reads until the limit is read or written. While the interrupt is high the reached flag is set.
- R5: A write to word offset 0 stores the written value ANDed with 0x7FFFFE00 as the limit, sets the count to zero and lowers the interrupt. The reached flag is left as it was.
- R6: A read of word offset 0 returns the limit with bit 31 zero, and clears both the reached flag and the interrupt. If a matching tick falls in the same cycle as that read, the flag and the interrupt end up set.
- R7: A write to word offset 2 stores the written value ANDed with 0x7FFFFE00 as the limit and leaves the count and the interrupt unchanged.
- R8: With a zero limit the counter runs freely and wraps at the top of its 22-bit field. It never sets the reached flag and never raises the interrupt.
- R9: Word offset 4 holds the mode register, which is the low NCPU bits of the written word. It reads back zero-extended and drives `cpu_mode`.
- R10: Writes to word offsets 1, 3 and 5..7 change nothing. Reads of offsets 2, 3 and 5..7 return zero.
- R11: A read request is answered in the following cycle, with `rd_valid` high for one cycle and the data on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable pulse every 500 ns |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one cycle when rdata holds a read result |
| irq | output | 1 | Level interrupt on limit match |
| cpu_mode | output | NCPU | Per-processor mode bits |

## Verification
The bench aims at the cycle where the count equals the limit. A design that reloads one tick early would never show the limit value. A design that compares after the reload would raise the interrupt one tick late. The bench also puts a limit read and a matching tick in the same cycle; a design that gives the clear priority would lose that match. Other cases it checks: a no-restart limit write, which a design that restarts the count would leave at zero; a zero limit, where a design that compares it would raise a spurious interrupt; and a limit write after a match, which a design that clears the flag would leave showing no reached bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int CNT_LSB = 9;
  localparam int CNT_W   = DATA_W - 1 - CNT_LSB;  // bits 30..9

  typedef enum logic [ADDR_W-1:0] {
    OFS_LIMIT      = 3'd0,
    OFS_COUNT      = 3'd1,
    OFS_LIMIT_KEEP = 3'd2,
    OFS_SPARE      = 3'd3,
    OFS_MODE       = 3'd4
  } tmr_ofs_e;
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  input  logic             restart,
  input  logic             ack,
  output logic [CNT_W-1:0] cnt,
  output logic             reached,
  output logic             irq
);
  logic             lim_nz;
  logic             at_limit;
  logic [CNT_W-1:0] cnt_inc;
  logic             hit;

  always_comb begin
    lim_nz   = |limit;
    at_limit = lim_nz && (cnt == limit);
    cnt_inc  = cnt + 1'b1;
    hit      = tick && lim_nz && !at_limit && (cnt_inc == limit) && !restart;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      reached <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (restart)
        cnt <= '0;
      else if (tick)
        cnt <= at_limit ? '0 : cnt_inc;

      // a new match outranks an acknowledge in the same cycle
      if (hit)
        reached <= 1'b1;
      else if (ack)
        reached <= 1'b0;

      if (hit)
        irq <= 1'b1;
      else if (ack || restart)
        irq <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              reached,
  output logic [CNT_W-1:0]  limit,
  output logic              restart,
  output logic              ack,
  output logic [NCPU-1:0]   mode,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  localparam int PAD_W = DATA_W - NCPU;

  logic              wr_lim, wr_keep, wr_mode;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_lim  = wr_en && (addr == OFS_LIMIT);
    wr_keep = wr_en && (addr == OFS_LIMIT_KEEP);
    wr_mode = wr_en && (addr == OFS_MODE);
    restart = wr_lim;
    ack     = rd_en && (addr == OFS_LIMIT);
    case (addr)
      OFS_LIMIT: rd_mux = {1'b0, limit, {CNT_LSB{1'b0}}};
      OFS_COUNT: rd_mux = {reached, cnt, {CNT_LSB{1'b0}}};
      OFS_MODE:  rd_mux = {{PAD_W{1'b0}}, mode};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit    <= '0;
      mode     <= '0;
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_lim || wr_keep)
        limit <= wdata[DATA_W-2:CNT_LSB];
      if (wr_mode)
        mode <= wdata[NCPU-1:0];
      rd_valid <= rd_en;
      if (rd_en)
        rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int NCPU = 4  // 1..31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              irq,
  output logic [NCPU-1:0]   cpu_mode
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             reached_q;
  logic             restart;
  logic             ack;

  tmr_regfile #(.NCPU(NCPU)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .cnt      (cnt_q),
    .reached  (reached_q),
    .limit    (lim_q),
    .restart  (restart),
    .ack      (ack),
    .mode     (cpu_mode),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .limit   (lim_q),
    .restart (restart),
    .ack     (ack),
    .cnt     (cnt_q),
    .reached (reached_q),
    .irq     (irq)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_valid,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  lim,
  input logic              reached
);
  assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(addr) == OFS_COUNT) |-> (rdata[CNT_LSB-1:0] == '0));

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(wr_en && addr == OFS_LIMIT)) |=> $stable(cnt));

  assert_irq_has_flag_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> reached);

  assert_limit_write_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_LIMIT) |=> (cnt == '0 && !irq));

  assert_limit_read_acks_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_LIMIT && !tick) |=> (!irq && !reached));

  assert_keep_count_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_LIMIT_KEEP && !tick) |=> $stable(cnt));

  assert_free_run_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(lim) != '0));

  assert_read_valid_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

bind tmr_top tmr_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .rd_valid (rd_valid),
  .irq      (irq),
  .cnt      (cnt_q),
  .lim      (lim_q),
  .reached  (reached_q)
);

// File: tb/tb_tmr_top.sv
module tb_tmr_top;
  localparam int NCPU = 4;
  localparam logic [21:0] FMASK = 22'h3FFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid, irq;
  logic [NCPU-1:0] cpu_mode;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  // reference state of the bench
  logic [21:0] m_cnt = '0, m_lim = '0;
  logic        m_reached = 1'b0, m_irq = 1'b0;
  logic [NCPU-1:0] m_mode = '0;

  always #10 clk = ~clk;

  tmr_top #(.NCPU(NCPU)) dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .irq(irq), .cpu_mode(cpu_mode)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [2:0] a);
    case (a)
      3'd0:    return {1'b0, m_lim, 9'b0};
      3'd1:    return {m_reached, m_cnt, 9'b0};
      3'd4:    return {{(32-NCPU){1'b0}}, m_mode};
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_tick();
    if (m_lim != 0 && m_cnt == m_lim) m_cnt = '0;
    else begin
      m_cnt = (m_cnt + 1'b1) & FMASK;
      if (m_lim != 0 && m_cnt == m_lim) begin m_reached = 1'b1; m_irq = 1'b1; end
    end
  endfunction

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rd_valid) begin
      if (sbq.size() == 0) check("R11 unexpected rd_valid", 32'h1, 32'h0);
      else begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1; model_tick();
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    case (a)
      3'd0: begin m_lim = d[30:9]; m_cnt = '0; m_irq = 1'b0; end
      3'd2: m_lim = d[30:9];
      3'd4: m_mode = d[NCPU-1:0];
      default: ;
    endcase
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, string tag, bit with_tick = 1'b0);
    item_t it;
    @(negedge clk); rd_en = 1'b1; addr = a; tick = with_tick;
    it.exp = exp_read(a); it.tag = tag;
    sbq.push_back(it);
    if (a == 3'd0) begin m_reached = 1'b0; m_irq = 1'b0; end
    if (with_tick) model_tick();
    @(negedge clk); rd_en = 1'b0; tick = 1'b0;
  endtask

  task automatic chk_irq(string tag);
    @(negedge clk);
    check(tag, {31'b0, irq}, {31'b0, m_irq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq("R1 irq after reset");
    rd(3'd0, "R1 limit after reset");
    rd(3'd1, "R1 count after reset");
    rd(3'd4, "R1 mode after reset");
    check("R1 cpu_mode", {28'b0, cpu_mode}, 32'h0);
    // R1 running: counts on ticks with zero limit
    ticks(3);
    rd(3'd1, "R1 R2 count runs after reset");
    // R2, R3 match sequence
    wr(3'd0, 32'h0000_0A00);          // limit 5
    rd(3'd1, "R5 count restarted");
    ticks(4);
    rd(3'd1, "R2 count before match");
    chk_irq("R3 no irq before match");
    ticks(1);
    chk_irq("R3 irq at match");
    rd(3'd1, "R3 reached bit at match");
    ticks(1);
    rd(3'd1, "R3 reload after match");
    chk_irq("R4 irq holds after count read and tick");
    ticks(2);
    chk_irq("R4 irq holds over ticks");
    rd(3'd0, "R6 limit read value");
    chk_irq("R6 irq cleared by limit read");
    rd(3'd1, "R6 reached cleared by limit read");
    // R5 write masking, reached kept
    ticks(3);                          // count 2 -> 5 match
    chk_irq("R3 second match");
    wr(3'd0, 32'hFFFF_FFFF);
    chk_irq("R5 irq lowered by limit write");
    rd(3'd1, "R5 reached kept, count zero");
    rd(3'd0, "R5 limit masked");
    // R7 limit change without restart
    wr(3'd0, 32'h0000_1400);          // limit 10
    ticks(3);
    wr(3'd2, 32'h8000_2001);          // limit 16, masked
    rd(3'd1, "R7 count kept by no-restart write");
    rd(3'd0, "R7 limit updated");
    ticks(13);
    chk_irq("R7 match at new limit");
    rd(3'd1, "R7 count at new limit");
    rd(3'd0, "R6 ack");
    // R6 race: ack and matching tick in same cycle
    wr(3'd0, 32'h0000_0400);          // limit 2
    ticks(1);
    rd(3'd0, "R6 read with matching tick", 1'b1);
    chk_irq("R6 match wins over ack");
    rd(3'd1, "R6 reached after race");
    rd(3'd0, "R6 final ack");
    // R10 ignored writes and zero reads
    rd(3'd1, "R10 count before ignored write");
    wr(3'd1, 32'h7FFF_FE00);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd1, "R10 count after ignored writes");
    rd(3'd0, "R10 limit after ignored writes");
    rd(3'd2, "R10 offset 2 reads zero");
    rd(3'd3, "R10 offset 3 reads zero");
    rd(3'd7, "R10 offset 7 reads zero");
    // R9 mode register
    wr(3'd4, 32'h0000_000A);
    rd(3'd4, "R9 mode readback");
    check("R9 cpu_mode port", {28'b0, cpu_mode}, 32'hA);
    wr(3'd4, 32'hFFFF_FFF5);
    rd(3'd4, "R9 mode upper bits dropped");
    check("R9 cpu_mode port wide write", {28'b0, cpu_mode}, 32'h5);
    // R8 free run
    wr(3'd0, 32'h0000_01FF);          // masks to zero limit
    ticks(40);
    chk_irq("R8 no irq in free run");
    rd(3'd1, "R8 free run count no reached");
    // R11 back-to-back reads
    @(negedge clk); rd_en = 1'b1; addr = 3'd1;
    sbq.push_back('{exp_read(3'd1), "R11 back-to-back first"});
    @(negedge clk); addr = 3'd4;
    sbq.push_back('{exp_read(3'd4), "R11 back-to-back second"});
    @(negedge clk); rd_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 queue drained", sbq.size(), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule